// File: doc/BRIEF.md
# Mode-Configurable Output Macrocell

This block is the output stage that sits behind one sum-of-products group of a programmable logic array. It takes the OR of the group's product terms and one extra product term. It also takes a shared clock pin and a shared active-low enable pin. From these it produces the value and the tri-state enable for one I/O pad, plus a feedback bit that returns to the array.

A global two-bit device mode sets how the cell works. Three per-cell configuration bits refine it:

- **Registered select:** chooses registered or combinational operation.
- **Input-only select:** turns the output off so the pad serves as an input.
- **Polarity invert:** makes the output active-low.

The mode decides where the output enable comes from: a constant, the extra product term, or the shared enable pin. The extra product term joins the sum when it is not acting as the enable.

The feedback path carries the register output for a registered cell and the pad value for a combinational cell. Some mode and configuration pairs are not allowed. For those, the cell disables its output and sets a sticky error flag, which stays set until reset.

Top module: `sop_out_cell`

## Requirements
- R1: `mode_i` encodes the global mode as 2'b00 simple, 2'b01 complex, 2'b10 registered; 2'b11 is reserved and always illegal.
- R2: In simple mode with `cfg_reg_i`=0 and `cfg_in_only_i`=0, `pad_oe_o` is 1 and `pad_out_o` is (`or_sum_i` OR `xpt_i`) XOR `cfg_inv_i`, combinationally.
- R3: In simple mode with `cfg_in_only_i`=1 and `cfg_reg_i`=0, `pad_oe_o` is 0 and the pad acts as an input: `fb_o` equals `pad_in_i`.
- R4: In complex mode with both `cfg_reg_i` and `cfg_in_only_i` at 0, `pad_oe_o` equals `xpt_i` and `pad_out_o` is `or_sum_i` XOR `cfg_inv_i`; `xpt_i` does not enter the sum.
- R5: In registered mode with `cfg_reg_i`=1, the cell register loads (`or_sum_i` OR `xpt_i`) on every rising `clk` edge, `pad_out_o` is the register XOR `cfg_inv_i`, and `pad_oe_o` is the inverse of `oe_n_pin_i`.
- R6: While `oe_n_pin_i` is 1 in registered operation, the register keeps loading on each edge, so its new value shows on `pad_out_o` and `fb_o` once the pin returns to 0.
- R7: In registered mode with `cfg_reg_i`=0 (and `cfg_in_only_i`=0), the cell is combinational: `pad_oe_o` equals `xpt_i` and `pad_out_o` is `or_sum_i` XOR `cfg_inv_i`.
- R8: `fb_o` is the register output before polarity when the cell is in legal registered operation, and `pad_in_i` in every other case.
- R9: These pairs are illegal:
  - mode 2'b11 with any configuration;
  - simple mode with `cfg_reg_i`=1;
  - complex mode with `cfg_reg_i`=1 or `cfg_in_only_i`=1;
  - registered mode with `cfg_in_only_i`=1.

  For an illegal pair, `pad_oe_o` is 0 in the same cycle, `pad_out_o` is `or_sum_i` XOR `cfg_inv_i`, and `fb_o` is `pad_in_i`.
- R10: `cfg_err_o` rises on the first clock edge at which an illegal pair is present and stays 1 until reset.
- R11: Synchronous active-high `rst` clears the register to the parameter `RST_VAL` (default 0) and clears `cfg_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock pin; clocks the cell register and the error flag |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Global device mode |
| cfg_reg_i | input | 1 | Per-cell select of registered operation |
| cfg_in_only_i | input | 1 | Per-cell select of pad-as-input (simple mode) |
| cfg_inv_i | input | 1 | Per-cell output polarity, 1 = active-low |
| or_sum_i | input | 1 | OR of the group's product terms |
| xpt_i | input | 1 | Extra product term of this cell |
| oe_n_pin_i | input | 1 | Shared active-low output enable pin |
| pad_in_i | input | 1 | Value read back from the pad |
| pad_out_o | output | 1 | Value driven toward the pad |
| pad_oe_o | output | 1 | Tri-state enable of the pad driver |
| fb_o | output | 1 | Feedback bit into the array |
| cfg_err_o | output | 1 | Sticky flag for an illegal mode and configuration pair |

## Verification
Some rules are checked by the assertions on every cycle:
- an illegal pair always holds the enable at zero;
- the error flag never falls outside reset;
- in registered operation, the enable follows the inverted enable pin and feedback equals the sum loaded on the previous edge;
- in combinational operation, feedback follows the pad.

Other behaviour shows only in the bench's scenarios:
- whether the extra product term enters the sum or drives the enable in each mode;
- polarity inversion on the combinational and registered paths;
- the register still loading while its output is off, seen once the pin re-enables it;
- the exact edge at which the error flag first rises, and its clearing by reset.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;

  typedef enum logic [1:0] {
    MODE_SIMPLE  = 2'b00,
    MODE_COMPLEX = 2'b01,
    MODE_REGD    = 2'b10,
    MODE_RSVD    = 2'b11
  } dev_mode_e;

  typedef enum logic [1:0] {
    OE_OFF   = 2'b00,
    OE_ON    = 2'b01,
    OE_PTERM = 2'b10,
    OE_PIN   = 2'b11
  } oe_src_e;

  typedef struct packed {
    logic    legal;
    logic    reg_op;
    logic    xpt_in_sum;
    oe_src_e oe_src;
  } cell_ctl_t;

endpackage

// File: rtl/sop_cell_decode.sv
module sop_cell_decode
  import sop_cell_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       cfg_reg_i,
  input  logic       cfg_in_only_i,
  output cell_ctl_t  ctl_o
);

  dev_mode_e mode;
  assign mode = dev_mode_e'(mode_i);

  always_comb begin
    ctl_o = '{legal: 1'b0, reg_op: 1'b0, xpt_in_sum: 1'b0, oe_src: OE_OFF};
    unique case (mode)
      MODE_SIMPLE: begin
        if (!cfg_reg_i) begin
          ctl_o.legal      = 1'b1;
          ctl_o.xpt_in_sum = 1'b1;
          ctl_o.oe_src     = cfg_in_only_i ? OE_OFF : OE_ON;
        end
      end
      MODE_COMPLEX: begin
        if (!cfg_reg_i && !cfg_in_only_i) begin
          ctl_o.legal  = 1'b1;
          ctl_o.oe_src = OE_PTERM;
        end
      end
      MODE_REGD: begin
        if (!cfg_in_only_i) begin
          ctl_o.legal = 1'b1;
          if (cfg_reg_i) begin
            ctl_o.reg_op     = 1'b1;
            ctl_o.xpt_in_sum = 1'b1;
            ctl_o.oe_src     = OE_PIN;
          end else begin
            ctl_o.oe_src = OE_PTERM;
          end
        end
      end
      default: begin
        ctl_o.legal = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sop_cell_flop.sv
module sop_cell_flop #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  // Loads on every edge, whether or not the pad driver is on.
  always_ff @(posedge clk) begin
    if (rst) q_o <= RST_VAL;
    else     q_o <= d_i;
  end

endmodule

// File: rtl/sop_cell_drive.sv
module sop_cell_drive
  import sop_cell_pkg::*;
(
  input  cell_ctl_t ctl_i,
  input  logic      sum_i,
  input  logic      xpt_i,
  input  logic      q_i,
  input  logic      inv_i,
  input  logic      oe_n_pin_i,
  input  logic      pad_in_i,
  output logic      pad_out_o,
  output logic      pad_oe_o,
  output logic      fb_o
);

  logic data_pre;

  assign data_pre  = ctl_i.reg_op ? q_i : sum_i;
  assign pad_out_o = data_pre ^ inv_i;
  assign fb_o      = ctl_i.reg_op ? q_i : pad_in_i;

  always_comb begin
    unique case (ctl_i.oe_src)
      OE_OFF:   pad_oe_o = 1'b0;
      OE_ON:    pad_oe_o = 1'b1;
      OE_PTERM: pad_oe_o = xpt_i;
      OE_PIN:   pad_oe_o = ~oe_n_pin_i;
      default:  pad_oe_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell
  import sop_cell_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       cfg_reg_i,
  input  logic       cfg_in_only_i,
  input  logic       cfg_inv_i,
  input  logic       or_sum_i,
  input  logic       xpt_i,
  input  logic       oe_n_pin_i,
  input  logic       pad_in_i,
  output logic       pad_out_o,
  output logic       pad_oe_o,
  output logic       fb_o,
  output logic       cfg_err_o
);

  cell_ctl_t ctl;
  logic      sum_eff;
  logic      q;

  sop_cell_decode u_decode (
    .mode_i        (mode_i),
    .cfg_reg_i     (cfg_reg_i),
    .cfg_in_only_i (cfg_in_only_i),
    .ctl_o         (ctl)
  );

  // The extra term joins the OR whenever it is not steering the enable.
  assign sum_eff = or_sum_i | (ctl.xpt_in_sum & xpt_i);

  sop_cell_flop #(.RST_VAL(RST_VAL)) u_flop (
    .clk (clk),
    .rst (rst),
    .d_i (sum_eff),
    .q_o (q)
  );

  sop_cell_drive u_drive (
    .ctl_i      (ctl),
    .sum_i      (sum_eff),
    .xpt_i      (xpt_i),
    .q_i        (q),
    .inv_i      (cfg_inv_i),
    .oe_n_pin_i (oe_n_pin_i),
    .pad_in_i   (pad_in_i),
    .pad_out_o  (pad_out_o),
    .pad_oe_o   (pad_oe_o),
    .fb_o       (fb_o)
  );

  always_ff @(posedge clk) begin
    if (rst)             cfg_err_o <= 1'b0;
    else if (!ctl.legal) cfg_err_o <= 1'b1;
  end

endmodule

// File: rtl/sop_out_cell_chk.sv
module sop_out_cell_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_i,
  input logic       cfg_reg_i,
  input logic       cfg_in_only_i,
  input logic       or_sum_i,
  input logic       xpt_i,
  input logic       oe_n_pin_i,
  input logic       pad_in_i,
  input logic       pad_oe_o,
  input logic       fb_o,
  input logic       cfg_err_o
);

  logic bad_pair;
  logic reg_run;
  logic comb_ok;

  assign bad_pair = (mode_i == 2'b11)
                  || (mode_i == 2'b00 && cfg_reg_i)
                  || (mode_i == 2'b01 && (cfg_reg_i || cfg_in_only_i))
                  || (mode_i == 2'b10 && cfg_in_only_i);
  assign reg_run  = (mode_i == 2'b10) && cfg_reg_i && !cfg_in_only_i;
  assign comb_ok  = !bad_pair && !reg_run;

  // R9
  illegal_oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    bad_pair |-> !pad_oe_o);

  // R10
  err_sets_chk: assert property (@(posedge clk) disable iff (rst)
    bad_pair |=> cfg_err_o);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_err_o) && !$past(rst)) |-> cfg_err_o);

  // R5
  pin_oe_chk: assert property (@(posedge clk) disable iff (rst)
    reg_run |-> (pad_oe_o == !oe_n_pin_i));

  // R8
  reg_fb_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_run && $past(reg_run) && !$past(rst)) |-> (fb_o == $past(or_sum_i | xpt_i)));

  // R8
  comb_fb_chk: assert property (@(posedge clk) disable iff (rst)
    comb_ok |-> (fb_o == pad_in_i));

endmodule

bind sop_out_cell sop_out_cell_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_i        (mode_i),
  .cfg_reg_i     (cfg_reg_i),
  .cfg_in_only_i (cfg_in_only_i),
  .or_sum_i      (or_sum_i),
  .xpt_i         (xpt_i),
  .oe_n_pin_i    (oe_n_pin_i),
  .pad_in_i      (pad_in_i),
  .pad_oe_o      (pad_oe_o),
  .fb_o          (fb_o),
  .cfg_err_o     (cfg_err_o)
);

// File: tb/sop_out_cell_tb_top.sv
module sop_out_cell_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_i = 2'b00;
  logic       cfg_reg_i = 1'b0;
  logic       cfg_in_only_i = 1'b0;
  logic       cfg_inv_i = 1'b0;
  logic       or_sum_i = 1'b0;
  logic       xpt_i = 1'b0;
  logic       oe_n_pin_i = 1'b0;
  logic       pad_in_i = 1'b0;
  logic       pad_out_o;
  logic       pad_oe_o;
  logic       fb_o;
  logic       cfg_err_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sop_out_cell dut_i (
    .clk           (clk),
    .rst           (rst),
    .mode_i        (mode_i),
    .cfg_reg_i     (cfg_reg_i),
    .cfg_in_only_i (cfg_in_only_i),
    .cfg_inv_i     (cfg_inv_i),
    .or_sum_i      (or_sum_i),
    .xpt_i         (xpt_i),
    .oe_n_pin_i    (oe_n_pin_i),
    .pad_in_i      (pad_in_i),
    .pad_out_o     (pad_out_o),
    .pad_oe_o      (pad_oe_o),
    .fb_o          (fb_o),
    .cfg_err_o     (cfg_err_o)
  );

  // {mode[1:0], reg, in_only, inv, or_sum, xpt, oe_n, pad_in, exp_out, exp_oe, exp_fb}
  localparam int NV = 13;
  localparam logic [11:0] VEC [NV] = '{
    12'b00_0_0_0_0_0_1_1_0_1_1, // R2 sum 0
    12'b00_0_0_0_0_1_1_0_1_1_0, // R2 extra term joins sum
    12'b00_0_0_1_1_0_0_1_0_1_1, // R2 inverted
    12'b00_0_1_0_1_1_0_1_1_0_1, // R3 pad as input
    12'b01_0_0_0_1_1_1_0_1_1_0, // R4 enable from term
    12'b01_0_0_1_0_0_1_1_1_0_1, // R4 term low, inverted
    12'b01_0_0_0_0_1_0_1_0_1_1, // R4 term not in sum
    12'b10_0_0_0_0_1_0_0_0_1_0, // R7
    12'b10_0_0_1_1_0_0_1_0_0_1, // R7 inverted
    12'b11_0_0_0_1_1_0_1_1_0_1, // R1 R9 reserved mode
    12'b00_1_0_0_0_1_0_0_0_0_0, // R9 simple registered
    12'b01_0_1_1_0_1_0_1_1_0_1, // R9 complex input-only
    12'b10_0_1_0_1_0_0_0_1_0_0  // R9 registered input-only
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic set_in(input logic [1:0] m, input logic r, input logic io, input logic inv,
                        input logic o, input logic x, input logic oen, input logic pin);
    mode_i = m; cfg_reg_i = r; cfg_in_only_i = io; cfg_inv_i = inv;
    or_sum_i = o; xpt_i = x; oe_n_pin_i = oen; pad_in_i = pin;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // Reset state, registered cell with zero sum
    set_in(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R11", "pad_out after reset", pad_out_o, 1'b0);
    chk("R11", "fb after reset", fb_o, 1'b0);
    chk("R11", "cfg_err after reset", cfg_err_o, 1'b0);

    // Table walk (combinational cases)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_in(VEC[i][11:10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6],
             VEC[i][5], VEC[i][4], VEC[i][3]);
      #1;
      chk("R2-table", $sformatf("vec %0d pad_out", i), pad_out_o, VEC[i][2]);
      chk("R2-table", $sformatf("vec %0d pad_oe", i), pad_oe_o, VEC[i][1]);
      chk("R8", $sformatf("vec %0d fb", i), fb_o, VEC[i][0]);
    end

    // R10: illegal pairs above set the sticky flag
    @(negedge clk);
    chk("R10", "cfg_err after illegal", cfg_err_o, 1'b1);
    set_in(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R10", "cfg_err sticky", cfg_err_o, 1'b1);
    do_reset();
    #1;
    chk("R11", "cfg_err cleared", cfg_err_o, 1'b0);

    // R10 rises on the first edge with an illegal pair
    @(negedge clk);
    set_in(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R10", "cfg_err before edge", cfg_err_o, 1'b0);
    @(negedge clk);
    chk("R10", "cfg_err after edge", cfg_err_o, 1'b1);
    do_reset();

    // R5 registered path
    @(negedge clk);
    set_in(2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R5", "pad_out before edge", pad_out_o, 1'b0);
    chk("R5", "pad_oe pin low", pad_oe_o, 1'b1);
    @(negedge clk);
    chk("R5", "pad_out after edge", pad_out_o, 1'b1);
    chk("R8", "fb is register", fb_o, 1'b1);
    pad_in_i = 1'b0;
    #1;
    chk("R8", "fb ignores pad", fb_o, 1'b1);

    // R6 disabled but still clocking
    oe_n_pin_i = 1'b1; or_sum_i = 1'b0;
    #1;
    chk("R5", "pad_oe pin high", pad_oe_o, 1'b0);
    @(negedge clk);
    chk("R6", "fb after load while off", fb_o, 1'b0);
    oe_n_pin_i = 1'b0;
    #1;
    chk("R6", "pad_oe re-enabled", pad_oe_o, 1'b1);
    chk("R6", "pad_out shows new load", pad_out_o, 1'b0);

    // R5 extra term joins the registered sum; polarity
    xpt_i = 1'b1;
    @(negedge clk);
    chk("R5", "register loaded term", fb_o, 1'b1);
    cfg_inv_i = 1'b1;
    #1;
    chk("R5", "registered inverted", pad_out_o, 1'b0);
    chk("R5", "pad_oe ignores term", pad_oe_o, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule